// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block drives the two timing inputs of a linear photodiode array: a start pulse that begins a scan and a pixel clock that shifts the pixels out. Frames begin on their own once reset is released. Each frame issues one start pulse and then a burst of exactly 133 pixel clock pulses at the selected rate. After the burst the pixel clock stays low for a selectable wait, and then the next frame begins.

Two 4-bit selectors set the behaviour. The rate selector picks a pixel clock frequency from a 16-entry table. The wait selector picks the idle time that follows the burst. The sensor starts integrating light after the 18th pixel clock, so the total integration time is the remaining 115 clock periods plus the wait. Both selectors are captured only at the start of a frame.

A warning output is raised whenever the rate selector points at a frequency outside the sensor's rated range. A one-cycle strobe marks the end of each burst. All timing is derived from the system clock, whose frequency is the parameter `SYS_HZ`.

Top module: `lin_sensor_seq`

## Requirements
- R1: While rst_ni is low, start_pulse_o, pix_clk_o and frame_done_o are low. The first frame starts at the first system clock edge after reset is released, so start_pulse_o is high in the cycle after that edge.
- R2: start_pulse_o stays high for exactly 2*H system cycles, where H is the half-period count of R3. It is followed by exactly H cycles in which start_pulse_o and pix_clk_o are both low, and then pix_clk_o rises.
- R3: Every high phase and every low phase of pix_clk_o inside a burst lasts H = round(SYS_HZ / (2*f)) system cycles. f is selected by rate_sel_i values 0..15 as 36k, 64k, 77k, 93k, 112k, 141k, 170k, 214k, 284k, 345k, 435k, 588k, 909k, 1000k, 1250k and 1670k Hz, in that order.
- R4: Each frame contains exactly 133 rising edges of pix_clk_o.
- R5: After the 133rd falling edge, pix_clk_o stays low for exactly W system cycles, and start_pulse_o rises in the next cycle. W = U * (SYS_HZ / 1_000_000), with U in microseconds selected by wait_sel_i values 0..15 as 5, 150, 300, 600, 900, 1200, 2400, 3000, 3750, 4500, 6000, 7600, 9000, 10400, 14900 and 19930. Setting 15 gives about 20 ms of total integration from pixel 18 at the fastest rate.
- R6: frame_done_o is high for exactly one system cycle per frame. That cycle is the first cycle in which pix_clk_o is low after the 133rd pulse.
- R7: range_warn_o is high whenever rate_sel_i is 0, 14 or 15, and low for every other value. It follows the input without waiting for a frame boundary.
- R8: rate_sel_i and wait_sel_i are captured only on the clock edge that starts a frame. A change made later in the frame affects only the following frames.
- R9: start_pulse_o and pix_clk_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 4 | Pixel clock rate setting |
| wait_sel_i | input | 4 | Post-burst wait setting |
| start_pulse_o | output | 1 | Scan start pulse to the sensor |
| pix_clk_o | output | 1 | Pixel clock to the sensor |
| range_warn_o | output | 1 | Rate setting outside the rated range |
| frame_done_o | output | 1 | One-cycle strobe after the 133rd pulse falls |

## Verification
The hardest case to reach from the ports is a selector change in the middle of a frame. The bench changes both selectors one cycle after a start pulse has risen, while the frame is running. It then checks that the running frame finishes with the old rate and wait, and that the next frame takes the new ones. It also runs one full frame at the slowest rate, where a divider that truncates would give 277 cycles instead of the rounded 278 and so shows up as an error. The bench uses a scaled `SYS_HZ` of 20 MHz so that this frame fits in the run.

// File: rtl/lss_pkg.sv
package lss_pkg;

  typedef enum logic [0:0] {ST_WAIT, ST_RUN} seq_state_e;

  function automatic int unsigned rate_hz(input int unsigned idx);
    case (idx)
      0:  return 36_000;
      1:  return 64_000;
      2:  return 77_000;
      3:  return 93_000;
      4:  return 112_000;
      5:  return 141_000;
      6:  return 170_000;
      7:  return 214_000;
      8:  return 284_000;
      9:  return 345_000;
      10: return 435_000;
      11: return 588_000;
      12: return 909_000;
      13: return 1_000_000;
      14: return 1_250_000;
      default: return 1_670_000;
    endcase
  endfunction

  function automatic int unsigned wait_us(input int unsigned idx);
    case (idx)
      0:  return 5;
      1:  return 150;
      2:  return 300;
      3:  return 600;
      4:  return 900;
      5:  return 1200;
      6:  return 2400;
      7:  return 3000;
      8:  return 3750;
      9:  return 4500;
      10: return 6000;
      11: return 7600;
      12: return 9000;
      13: return 10400;
      14: return 14900;
      default: return 19930;
    endcase
  endfunction

  // nearest whole count of system cycles per half period
  function automatic int unsigned half_cycles(input int unsigned sys_hz, input int unsigned idx);
    return (sys_hz + rate_hz(idx)) / (2 * rate_hz(idx));
  endfunction

  function automatic longint unsigned wait_cycles(input int unsigned sys_hz, input int unsigned idx);
    return longint'(wait_us(idx)) * longint'(sys_hz / 1_000_000);
  endfunction

endpackage

// File: rtl/lss_down_cnt.sv
module lss_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lss_sel_lut.sv
module lss_sel_lut
  import lss_pkg::*;
#(
  parameter int unsigned SYS_HZ = 200_000_000,
  parameter int          HW     = 12,
  parameter int          WW     = 22
) (
  input  logic [3:0]    rate_idx_i,
  input  logic [3:0]    wait_idx_i,
  output logic [HW-1:0] half_m1_o,
  output logic [WW-1:0] wait_m1_o
);
  localparam int NSEL = 16;

  logic [HW-1:0] half_tab [NSEL];
  logic [WW-1:0] wait_tab [NSEL];

  for (genvar i = 0; i < NSEL; i++) begin : g_tab
    assign half_tab[i] = HW'(half_cycles(SYS_HZ, i) - 1);
    assign wait_tab[i] = WW'(wait_cycles(SYS_HZ, i) - 1);
  end

  assign half_m1_o = half_tab[rate_idx_i];
  assign wait_m1_o = wait_tab[wait_idx_i];
endmodule

// File: rtl/lin_sensor_seq.sv
module lin_sensor_seq
  import lss_pkg::*;
#(
  parameter int unsigned SYS_HZ = 200_000_000,
  parameter int          PULSES = 133
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] rate_sel_i,
  input  logic [3:0] wait_sel_i,
  output logic       start_pulse_o,
  output logic       pix_clk_o,
  output logic       range_warn_o,
  output logic       frame_done_o
);
  localparam int unsigned     HALF_MAX = half_cycles(SYS_HZ, 0);
  localparam longint unsigned WAIT_MAX = wait_cycles(SYS_HZ, 15);
  localparam int HW      = $clog2(HALF_MAX + 1);
  localparam int WW      = $clog2(WAIT_MAX + 1);
  // half phases: 0,1 start pulse; 2 gap; odd phases from 3 are clock high
  localparam int LAST_PH = 2 * PULSES + 1;
  localparam int PW      = $clog2(LAST_PH + 1);

  seq_state_e    state_q;
  logic [PW-1:0] phase_q;
  logic [3:0]    rate_q, wait_q;
  logic          done_q;
  logic          half_zero, wait_zero;
  logic          start, run_end, half_load;
  logic [HW-1:0] half_m1;
  logic [WW-1:0] wait_m1;

  assign start     = (state_q == ST_WAIT) && wait_zero;
  assign run_end   = (state_q == ST_RUN) && half_zero && (phase_q == PW'(LAST_PH));
  assign half_load = start || ((state_q == ST_RUN) && half_zero && !run_end);

  lss_sel_lut #(.SYS_HZ(SYS_HZ), .HW(HW), .WW(WW)) i_lut (
    .rate_idx_i (start ? rate_sel_i : rate_q),
    .wait_idx_i (wait_q),
    .half_m1_o  (half_m1),
    .wait_m1_o  (wait_m1)
  );

  lss_down_cnt #(.W(HW)) i_half_cnt (
    .clk_i, .rst_ni,
    .load_i     (half_load),
    .load_val_i (half_m1),
    .zero_o     (half_zero)
  );

  lss_down_cnt #(.W(WW)) i_wait_cnt (
    .clk_i, .rst_ni,
    .load_i     (run_end),
    .load_val_i (wait_m1),
    .zero_o     (wait_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      phase_q <= '0;
      rate_q  <= '0;
      wait_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= run_end;
      if (start) begin
        state_q <= ST_RUN;
        phase_q <= '0;
        rate_q  <= rate_sel_i;
        wait_q  <= wait_sel_i;
      end else if (state_q == ST_RUN && half_zero) begin
        if (run_end) state_q <= ST_WAIT;
        else         phase_q <= phase_q + PW'(1);
      end
    end
  end

  assign start_pulse_o = (state_q == ST_RUN) && (phase_q < PW'(2));
  assign pix_clk_o     = (state_q == ST_RUN) && phase_q[0] && (phase_q >= PW'(3));
  assign frame_done_o  = done_q;
  assign range_warn_o  = (rate_sel_i == 4'd0) || (rate_sel_i >= 4'd14);

  assert_si_clk_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_pulse_o && pix_clk_o));

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  assert_done_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (!pix_clk_o && $past(pix_clk_o)));

  assert_quiet_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (!pix_clk_o && !start_pulse_o));

  assert_sel_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q == ST_RUN)) |-> ($stable(rate_q) && $stable(wait_q)));
endmodule

// File: tb/test_lin_sensor_seq.sv
`timescale 1ns/1ps
module test_lin_sensor_seq;
  localparam int unsigned SYS_HZ = 20_000_000;
  localparam int PULSES = 133;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rate_sel = 4'd15;
  logic [3:0] wait_sel = 4'd0;
  logic       start_pulse, pix_clk, range_warn, frame_done;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lin_sensor_seq #(.SYS_HZ(SYS_HZ), .PULSES(PULSES)) i_lin_sensor_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .rate_sel_i    (rate_sel),
    .wait_sel_i    (wait_sel),
    .start_pulse_o (start_pulse),
    .pix_clk_o     (pix_clk),
    .range_warn_o  (range_warn),
    .frame_done_o  (frame_done)
  );

  function automatic int exp_half(input int idx);
    int f [16] = '{36_000, 64_000, 77_000, 93_000, 112_000, 141_000, 170_000, 214_000,
                   284_000, 345_000, 435_000, 588_000, 909_000, 1_000_000, 1_250_000, 1_670_000};
    return (int'(SYS_HZ) + f[idx]) / (2 * f[idx]);
  endfunction

  function automatic int exp_wait(input int idx);
    int u [16] = '{5, 150, 300, 600, 900, 1200, 2400, 3000,
                   3750, 4500, 6000, 7600, 9000, 10400, 14900, 19930};
    return u[idx] * (int'(SYS_HZ) / 1_000_000);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // R1: quiet during reset, self start after release
  task automatic t_reset();
    repeat (3) begin
      step();
      check(!start_pulse && !pix_clk && !frame_done, "R1 outputs in reset",
            {start_pulse, pix_clk, frame_done}, 0);
    end
    rst_n = 1'b1;
    step();
    check(start_pulse == 1'b1, "R1 first start pulse", start_pulse, 1);
  endtask

  // entered on the first sample with start_pulse high; leaves on the next one
  task automatic t_frame(input int ridx, input int widx, input string tag);
    int h = exp_half(ridx);
    int w = exp_wait(widx);
    int n, hi, lo, pulses, bad_hi, bad_lo, dcount;
    bit dpos;
    n = 0;
    while (start_pulse) begin n++; step(); end
    check(n == 2 * h, {"R2 start width ", tag}, n, 2 * h);
    n = 0;
    while (!pix_clk) begin n++; step(); end
    check(n == h, {"R2 gap before clock ", tag}, n, h);
    pulses = 0; bad_hi = 0; bad_lo = 0; dcount = 0; dpos = 1'b0; lo = 0;
    do begin
      hi = 0;
      while (pix_clk) begin hi++; step(); end
      pulses++;
      if (hi != h) bad_hi++;
      lo = 0;
      while (!pix_clk && !start_pulse) begin
        if (frame_done) begin
          dcount++;
          if (lo == 0 && pulses == PULSES) dpos = 1'b1;
        end
        lo++;
        step();
      end
      if (!start_pulse && lo != h) bad_lo++;
    end while (!start_pulse);
    check(pulses == PULSES, {"R4 pulse count ", tag}, pulses, PULSES);
    check(bad_hi == 0, {"R3 high phases off ", tag}, bad_hi, 0);
    check(bad_lo == 0, {"R3 low phases off ", tag}, bad_lo, 0);
    check(lo == w, {"R5 post-burst wait ", tag}, lo, w);
    check(dcount == 1, {"R6 done strobe count ", tag}, dcount, 1);
    check(dpos, {"R6 done strobe position ", tag}, dpos, 1);
  endtask

  // R8: change both selectors while a frame runs
  task automatic t_midframe();
    step();
    rate_sel = 4'd13;
    wait_sel = 4'd1;
    n_frame_rest();
  endtask

  task automatic n_frame_rest();
    int n = 1;
    while (start_pulse) begin n++; step(); end
    check(n == 2 * exp_half(15), "R8 old rate kept in start pulse", n, 2 * exp_half(15));
    while (!start_pulse) step();
  endtask

  // R7: warning follows the live selector
  task automatic t_warn();
    for (int i = 0; i < 16; i++) begin
      rate_sel = 4'(i);
      #1;
      check(range_warn == (i == 0 || i == 14 || i == 15), "R7 range warning",
            range_warn, (i == 0 || i == 14 || i == 15));
    end
  endtask

  initial begin
    t_reset();
    t_frame(15, 0, "rate15 wait0");
    t_frame(15, 0, "rate15 wait0 again");
    t_midframe();
    // frame after the change must use rate 13 and wait 1 (R8)
    rate_sel = 4'd0;
    wait_sel = 4'd0;
    t_frame(13, 1, "R8 new settings rate13 wait1");
    t_frame(0, 0, "rate0 rounding");
    t_warn();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule